// File: doc/BRIEF.md
# Key-Search Job Sequencer

This block runs one key-search job at a time between two host-side queues and a search engine. The block reads a fixed set of configuration words from an inbound queue: the known plaintext block, the matching ciphertext block, and the upper key field that selects the slice of the key space to search. It then starts the engine and waits for the engine to report either a match or the end of the slice. It writes the outcome to an outbound queue as two words, and then pulses an interrupt so that host software knows the answer is waiting.

Both queues use a request/acknowledge handshake. A word moves in any cycle where the request and the acknowledge are both high. Either side may insert stall cycles of any length. A synchronous software reset stops the job at any point and drops any outstanding request. After the interrupt pulse, or after a software reset, the block is ready to take the next job.

Top module: `job_ctl`

## Requirements
- R1: After the asynchronous reset is released, the block waits for configuration. `wf_rd_req_o` is high, and `rf_wr_req_o`, `eng_start_o` and `irq_o` are low.
- R2: A job consists of five inbound words taken in this order: plaintext upper 32 bits, plaintext lower 32 bits, ciphertext upper 32 bits, ciphertext lower 32 bits, then the upper key field. The key field is taken from bits 23:0 of the fifth word, and bits 31:24 of that word are ignored. These values appear on `eng_pt_o`, `eng_ct_o` and `eng_khi_o` whenever `eng_start_o` is high.
- R3: An inbound word is consumed only in a cycle where `wf_rd_req_o` and `wf_rd_ack_i` are both high. While the acknowledge is low, the word on `wf_data_i` has no effect, and stall cycles lose no word.
- R4: `eng_start_o` is a one-cycle pulse. It occurs in the cycle after the fifth word is accepted. From that pulse until the job ends, `wf_rd_req_o` stays low.
- R5: While `eng_busy_i` is high and `eng_found_i` is low, the block keeps waiting and raises no request on either queue. It stops waiting in the first cycle where `eng_found_i` is high or `eng_busy_i` is low.
- R6: If the wait ends with `eng_found_i` high, the block returns the value of `eng_key_i` from that cycle as two outbound words, upper 32 bits first. A later change on `eng_key_i` does not alter the result.
- R7: If the wait ends with `eng_busy_i` low and `eng_found_i` low, the block returns failure as two outbound words that are both zero.
- R8: The second result word is offered only after the first word has been acknowledged. While `rf_wr_req_o` is high and `rf_wr_ack_i` is low, `rf_wr_req_o` and `rf_data_o` stay unchanged.
- R9: `irq_o` is high for exactly one cycle: the cycle after the second result word is accepted. In the following cycle the block waits for the next job's configuration again.
- R10: In a cycle where `sw_rst_i` is high, both requests are low. `eng_abort_o` is high in that cycle only if the engine has been started and the job has not yet produced its result. In the next cycle the block waits for configuration with its word counts cleared, so no partial job and no aborted result is carried over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset of the job sequence |
| wf_rd_req_o | output | 1 | Read request to the inbound queue |
| wf_rd_ack_i | input | 1 | Inbound queue acknowledge, word valid |
| wf_data_i | input | 32 | Inbound configuration word |
| rf_wr_req_o | output | 1 | Write request to the outbound queue |
| rf_wr_ack_i | input | 1 | Outbound queue acknowledge, word taken |
| rf_data_o | output | 32 | Outbound result word |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_abort_o | output | 1 | Abort of a running search |
| eng_busy_i | input | 1 | Engine is still searching |
| eng_found_i | input | 1 | Engine has found the key |
| eng_key_i | input | 64 | Key found by the engine |
| eng_pt_o | output | 64 | Known plaintext |
| eng_ct_o | output | 64 | Known ciphertext |
| eng_khi_o | output | 24 | Upper key field selecting the slice |
| irq_o | output | 1 | Job-complete interrupt pulse |

## Verification
The assertions assume that the engine raises `eng_busy_i` in the cycle after `eng_start_o`. The wait state relies on this, because it would otherwise read a low busy signal as an immediate failure. The bench engine model raises busy at the same clock edge that accepts the start pulse, and lowers it only when it reports a result. The assertions also assume that `sw_rst_i` is not raised in a cycle where a queue acknowledges a word. The stimulus therefore applies software reset only when the inbound queue model holds no word and no result is being written.

// File: rtl/jc_pkg.sv
package jc_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_START,
    ST_WAIT,
    ST_SEND,
    ST_IRQ
  } jc_state_e;
endpackage

// File: rtl/jc_cfg_load.sv
module jc_cfg_load #(
  parameter int DATA_W   = 32,
  parameter int BLOCK_W  = 64,
  parameter int KEY_HI_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                take_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic                last_o,
  output logic [BLOCK_W-1:0]  pt_o,
  output logic [BLOCK_W-1:0]  ct_o,
  output logic [KEY_HI_W-1:0] khi_o
);
  localparam int BLK_WORDS = BLOCK_W / DATA_W;
  localparam int BLK_ALL   = 2 * BLK_WORDS;
  localparam int CFG_WORDS = BLK_ALL + 1;
  localparam int CNT_W     = $clog2(CFG_WORDS);

  logic [CNT_W-1:0]    cnt_q;
  logic [DATA_W-1:0]   words_q [BLK_ALL];
  logic [KEY_HI_W-1:0] khi_q;

  assign last_o = (cnt_q == CNT_W'(CFG_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (take_i)      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  for (genvar g = 0; g < BLK_ALL; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  words_q[g] <= '0;
      else if (take_i && cnt_q == CNT_W'(g))        words_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               khi_q <= '0;
    else if (take_i && last_o) khi_q <= data_i[KEY_HI_W-1:0];
  end

  // upper word of each block arrives first
  always_comb begin
    for (int b = 0; b < BLK_WORDS; b++) begin
      pt_o[BLOCK_W-1-b*DATA_W -: DATA_W] = words_q[b];
      ct_o[BLOCK_W-1-b*DATA_W -: DATA_W] = words_q[BLK_WORDS+b];
    end
  end

  assign khi_o = khi_q;
endmodule

// File: rtl/jc_result_tx.sv
module jc_result_tx #(
  parameter int DATA_W  = 32,
  parameter int BLOCK_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic               found_i,
  input  logic [BLOCK_W-1:0] key_i,
  input  logic               take_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               last_o
);
  localparam int BLK_WORDS = BLOCK_W / DATA_W;
  localparam int IDX_W     = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;

  logic [BLOCK_W-1:0] res_q;
  logic [IDX_W-1:0]   idx_q;

  assign last_o = (idx_q == IDX_W'(BLK_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (load_i) begin
      res_q <= found_i ? key_i : '0;
      idx_q <= '0;
    end else if (take_i) begin
      idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  always_comb begin
    data_o = '0;
    for (int b = 0; b < BLK_WORDS; b++)
      if (idx_q == IDX_W'(b)) data_o = res_q[BLOCK_W-1-b*DATA_W -: DATA_W];
  end
endmodule

// File: rtl/job_ctl.sv
module job_ctl #(
  parameter int DATA_W   = 32,
  parameter int BLOCK_W  = 64,
  parameter int KEY_HI_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_rst_i,
  output logic                wf_rd_req_o,
  input  logic                wf_rd_ack_i,
  input  logic [DATA_W-1:0]   wf_data_i,
  output logic                rf_wr_req_o,
  input  logic                rf_wr_ack_i,
  output logic [DATA_W-1:0]   rf_data_o,
  output logic                eng_start_o,
  output logic                eng_abort_o,
  input  logic                eng_busy_i,
  input  logic                eng_found_i,
  input  logic [BLOCK_W-1:0]  eng_key_i,
  output logic [BLOCK_W-1:0]  eng_pt_o,
  output logic [BLOCK_W-1:0]  eng_ct_o,
  output logic [KEY_HI_W-1:0] eng_khi_o,
  output logic                irq_o
);
  import jc_pkg::*;

  jc_state_e state_q, state_d;
  logic rd_take, wr_take, cfg_last, res_last, search_end, res_load;

  assign wf_rd_req_o = (state_q == ST_LOAD) && !sw_rst_i;
  assign rf_wr_req_o = (state_q == ST_SEND) && !sw_rst_i;
  assign rd_take     = wf_rd_req_o && wf_rd_ack_i;
  assign wr_take     = rf_wr_req_o && rf_wr_ack_i;
  assign eng_start_o = (state_q == ST_START);
  assign irq_o       = (state_q == ST_IRQ);
  assign eng_abort_o = sw_rst_i && (state_q == ST_START || state_q == ST_WAIT);
  assign search_end  = eng_found_i || !eng_busy_i;
  assign res_load    = (state_q == ST_WAIT) && search_end && !sw_rst_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOAD:  if (rd_take && cfg_last) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (search_end) state_d = ST_SEND;
      ST_SEND:  if (wr_take && res_last) state_d = ST_IRQ;
      ST_IRQ:   state_d = ST_LOAD;
      default:  state_d = ST_LOAD;
    endcase
    if (sw_rst_i) state_d = ST_LOAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOAD;
    else         state_q <= state_d;
  end

  jc_cfg_load #(.DATA_W(DATA_W), .BLOCK_W(BLOCK_W), .KEY_HI_W(KEY_HI_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sw_rst_i),
    .take_i (rd_take),
    .data_i (wf_data_i),
    .last_o (cfg_last),
    .pt_o   (eng_pt_o),
    .ct_o   (eng_ct_o),
    .khi_o  (eng_khi_o)
  );

  jc_result_tx #(.DATA_W(DATA_W), .BLOCK_W(BLOCK_W)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sw_rst_i),
    .load_i  (res_load),
    .found_i (eng_found_i),
    .key_i   (eng_key_i),
    .take_i  (wr_take),
    .data_o  (rf_data_o),
    .last_o  (res_last)
  );
endmodule

// File: rtl/jc_checker.sv
module jc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sw_rst_i,
  input logic              wf_rd_req_o,
  input logic              rf_wr_req_o,
  input logic              rf_wr_ack_i,
  input logic [DATA_W-1:0] rf_data_o,
  input logic              eng_start_o,
  input logic              eng_abort_o,
  input logic              irq_o
);
  p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o && !wf_rd_req_o);

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_after_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rf_wr_req_o && rf_wr_ack_i));

  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_wr_req_o && !rf_wr_ack_i |=> sw_rst_i || (rf_wr_req_o && $stable(rf_data_o)));

  p_swrst_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |-> !wf_rd_req_o && !rf_wr_req_o);

  p_abort_needs_swrst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_abort_o |-> sw_rst_i);

  p_swrst_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> !rf_wr_req_o && !irq_o && !eng_start_o);
endmodule

bind job_ctl jc_checker #(.DATA_W(DATA_W)) u_jc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sw_rst_i    (sw_rst_i),
  .wf_rd_req_o (wf_rd_req_o),
  .rf_wr_req_o (rf_wr_req_o),
  .rf_wr_ack_i (rf_wr_ack_i),
  .rf_data_o   (rf_data_o),
  .eng_start_o (eng_start_o),
  .eng_abort_o (eng_abort_o),
  .irq_o       (irq_o)
);

// File: tb/tb_job_ctl.sv
module tb_job_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        wf_rd_req, wf_rd_ack = 1'b0;
  logic [31:0] wf_data = '0;
  logic        rf_wr_req, rf_wr_ack = 1'b0;
  logic [31:0] rf_data;
  logic        eng_start, eng_abort;
  logic        eng_busy = 1'b0, eng_found = 1'b0;
  logic [63:0] eng_key = '0;
  logic [63:0] eng_pt, eng_ct;
  logic [23:0] eng_khi;
  logic        irq;

  job_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst),
    .wf_rd_req_o(wf_rd_req), .wf_rd_ack_i(wf_rd_ack), .wf_data_i(wf_data),
    .rf_wr_req_o(rf_wr_req), .rf_wr_ack_i(rf_wr_ack), .rf_data_o(rf_data),
    .eng_start_o(eng_start), .eng_abort_o(eng_abort),
    .eng_busy_i(eng_busy), .eng_found_i(eng_found), .eng_key_i(eng_key),
    .eng_pt_o(eng_pt), .eng_ct_o(eng_ct), .eng_khi_o(eng_khi), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] feed_q[$];
  logic [31:0] exp_q[$];
  int ack_gap = 0, wr_gap = 0;
  int jobs_done = 0;
  bit chk_wait = 1'b1;
  bit plan_found;
  int plan_delay;
  logic [63:0] plan_key, exp_pt, exp_ct;
  logic [23:0] exp_khi;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inbound queue model (R3: garbage on data while ack low)
  initial begin
    int fc = 0;
    forever begin
      @(negedge clk);
      fc++;
      if (wf_rd_req && feed_q.size() > 0 && (fc % (ack_gap + 1)) == 0) begin
        wf_rd_ack = 1'b1;
        wf_data   = feed_q.pop_front();
      end else begin
        wf_rd_ack = 1'b0;
        wf_data   = 32'hBAD0_BAD0;
      end
    end
  end

  // outbound monitor / scoreboard
  initial begin
    int mc = 0, wcnt = 0, irq_chk = 0;
    bit held = 1'b0;
    logic [31:0] held_data = '0;
    forever begin
      @(negedge clk);
      mc++;
      if (irq_chk == 2) begin
        chk(irq == 1'b1, "R9 irq pulse after last word", 64'(irq), 64'd1);
        irq_chk = 1;
      end else if (irq_chk == 1) begin
        chk(irq == 1'b0 && wf_rd_req == 1'b1, "R9 irq single cycle, back to load",
            {62'd0, irq, wf_rd_req}, 64'd1);
        irq_chk = 0;
        jobs_done++;
      end else if (irq) begin
        chk(1'b0, "R9 unexpected irq", 64'd1, 64'd0);
      end
      if (rf_wr_req && held)
        chk(rf_data == held_data, "R8 data stable while stalled", 64'(rf_data), 64'(held_data));
      held = 1'b0;
      if (rf_wr_req && (mc % (wr_gap + 1)) == 0) begin
        rf_wr_ack = 1'b1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected result word", 64'(rf_data), 64'd0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(rf_data == e, plan_found ? "R6 found key word" : "R7 failure word",
              64'(rf_data), 64'(e));
        end
        wcnt++;
        if (wcnt == 2) begin
          wcnt = 0;
          irq_chk = 2;
        end
      end else begin
        rf_wr_ack = 1'b0;
        if (rf_wr_req) begin
          held = 1'b1;
          held_data = rf_data;
        end
      end
    end
  end

  // search engine model: busy rises with the start edge
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt > 0) begin
        if (chk_wait)
          chk(!rf_wr_req && !wf_rd_req, "R5 no requests while searching",
              {62'd0, rf_wr_req, wf_rd_req}, 64'd0);
        cnt--;
        if (cnt == 0) begin
          if (plan_found) begin
            eng_found = 1'b1;
            eng_key   = plan_key;
          end else begin
            eng_busy = 1'b0;
          end
        end
      end else if (eng_found) begin
        eng_found = 1'b0;
        eng_busy  = 1'b0;
        eng_key   = ~plan_key;
      end
      if (eng_start) begin
        chk(eng_pt == exp_pt, "R2 plaintext at start", eng_pt, exp_pt);
        chk(eng_ct == exp_ct, "R2 ciphertext at start", eng_ct, exp_ct);
        chk(eng_khi == exp_khi, "R2 key field at start", 64'(eng_khi), 64'(exp_khi));
        chk(!wf_rd_req, "R4 no read during start", 64'(wf_rd_req), 64'd0);
        eng_busy = 1'b1;
        cnt = plan_delay;
      end
    end
  end

  task automatic load_job(input logic [63:0] pt, input logic [63:0] ct, input logic [23:0] khi,
                          input bit found, input int delay, input logic [63:0] key);
    exp_pt = pt; exp_ct = ct; exp_khi = khi;
    plan_found = found; plan_delay = delay; plan_key = key;
    feed_q.push_back(pt[63:32]);
    feed_q.push_back(pt[31:0]);
    feed_q.push_back(ct[63:32]);
    feed_q.push_back(ct[31:0]);
    feed_q.push_back({8'hA5, khi});
  endtask

  task automatic run_job(input logic [63:0] pt, input logic [63:0] ct, input logic [23:0] khi,
                         input bit found, input int delay, input logic [63:0] key);
    int target;
    target = jobs_done + 1;
    load_job(pt, ct, khi, found, delay, key);
    exp_q.push_back(found ? key[63:32] : 32'd0);
    exp_q.push_back(found ? key[31:0]  : 32'd0);
    while (jobs_done < target) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual=timeout expected=all jobs done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wf_rd_req == 1'b1, "R1 read request after reset", 64'(wf_rd_req), 64'd1);
    chk(!rf_wr_req && !irq && !eng_start, "R1 other outputs idle",
        {61'd0, rf_wr_req, irq, eng_start}, 64'd0);

    run_job(64'h0123_4567_89AB_CDEF, 64'h85E8_1354_0F0A_B405, 24'h13_3457,
            1'b1, 5, 64'h1334_5779_9BBC_DFF1);
    run_job(64'hFEDC_BA98_7654_3210, 64'h1111_2222_3333_4444, 24'hABCDEF,
            1'b0, 8, 64'h0);

    // R3 / R8: stalls on both queues
    ack_gap = 2; wr_gap = 3;
    run_job(64'hDEAD_BEEF_0000_0001, 64'hCAFE_F00D_1234_5678, 24'h00_0001,
            1'b1, 3, 64'hA5A5_5A5A_0F0F_F0F0);

    // R10: software reset in the middle of configuration
    ack_gap = 0; wr_gap = 0;
    feed_q.push_back(32'h7777_7777);
    feed_q.push_back(32'h8888_8888);
    while (feed_q.size() > 0) @(negedge clk);
    @(negedge clk);
    sw_rst = 1'b1;
    #1;
    chk(!wf_rd_req && !eng_abort, "R10 reset drops read request, no abort in load",
        {62'd0, wf_rd_req, eng_abort}, 64'd0);
    @(negedge clk);
    sw_rst = 1'b0;
    #1;
    chk(wf_rd_req == 1'b1, "R10 back to load after reset", 64'(wf_rd_req), 64'd1);
    run_job(64'h1020_3040_5060_7080, 64'h0102_0304_0506_0708, 24'hFF_FFFF,
            1'b1, 2, 64'h0000_0000_FFFF_FFFF);

    // R10: software reset while searching
    chk_wait = 1'b0;
    load_job(64'h5555_AAAA_5555_AAAA, 64'hAAAA_5555_AAAA_5555, 24'h55_AA55,
             1'b1, 40, 64'h1111_1111_1111_1111);
    while (!eng_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    sw_rst = 1'b1;
    #1;
    chk(eng_abort == 1'b1, "R10 abort during search", 64'(eng_abort), 64'd1);
    chk(!wf_rd_req && !rf_wr_req, "R10 no requests during reset",
        {62'd0, wf_rd_req, rf_wr_req}, 64'd0);
    @(negedge clk);
    sw_rst = 1'b0;
    #1;
    chk(wf_rd_req == 1'b1, "R10 idle after abort", 64'(wf_rd_req), 64'd1);
    while (eng_busy || eng_found) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(jobs_done == 4, "R10 aborted job returns nothing", 64'(jobs_done), 64'd4);
    chk_wait = 1'b1;

    ack_gap = 1; wr_gap = 1;
    run_job(64'h0F1E_2D3C_4B5A_6978, 64'h8796_A5B4_C3D2_E1F0, 24'h80_0000,
            1'b0, 1, 64'h0);
    run_job(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 24'h0,
            1'b1, 1, 64'hFFFF_0000_FFFF_0000);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule